// File: doc/BRIEF.md
# Temperature-Indexed Two-Channel Setting Lookup

This block turns a signed temperature sample into two 8-bit setting codes, one per channel, that would drive the taps of two resistor arrays. Each channel has its own table in on-chip register storage. The table holds one code for each 2 °C band between -40 °C and +102 °C, which gives 72 entries. When the sensor signals a finished conversion, the block works out the band index and clamps it to the table range. It then reads both tables and registers the two codes.

A control bit selects automatic or manual operation. With the bit clear, the table lookup is bypassed and each output takes its code from a directly written manual register. All storage is loaded through one byte write port. A page number and a byte address select the target. Outputs change only at a conversion strobe or, in manual mode, at a manual-register write. Table loads never disturb the codes being driven.

Top module: `temp_lut_ctrl`

## Requirements
- R1: After reset both codes are 00h, and the block is in manual mode: a strobe taken before any control write reloads the manual registers, which are 00h, whatever the tables hold.
- R2: In automatic mode the table index is floor((T + 40) / 2) for a temperature T in whole degrees Celsius.
- R3: Any temperature below -40 uses index 0.
- R4: Any temperature of +102 or above uses index 71, and the index never leaves the range 0 to 71.
- R5: In automatic mode, the cycle after a strobe cycle (conv_done_i high at a rising edge) each output shows its own table entry at the index of the temperature sampled in that cycle.
- R6: Table writes never change an output. With no strobe and no manual-register write, both outputs hold.
- R7: Page 1 address 82h is the channel 0 manual register and 83h is the channel 1 manual register. In manual mode a write to one of them appears on that channel's output the next cycle. A strobe in manual mode reloads both outputs from these registers.
- R8: Bit 0 of page 1 address 80h is the mode bit (1 = automatic, 0 = manual). Changing it does not change the outputs. The new mode applies from the next strobe.
- R9: Page 2 holds the channel 0 table and page 3 holds the channel 1 table. Address 80h + k writes entry k, for k from 0 to 71 (80h to C7h).
- R10: Writes to table-page addresses C8h to FFh or below 80h, and writes to pages 0 and 1 outside the defined registers, leave every table entry unchanged.
- R11: The two channels use independent tables, so the same index can yield different codes.
- R12: In automatic mode a write to a manual register does not change the outputs. The written value is used once manual mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_i | input | TEMP_W (10) | Signed temperature sample in whole °C |
| conv_done_i | input | 1 | One-cycle strobe marking a finished conversion |
| wr_en_i | input | 1 | Byte write enable |
| wr_page_i | input | 2 | Target page: 1 control, 2 channel 0 table, 3 channel 1 table |
| wr_addr_i | input | 8 | Byte address within the page |
| wr_data_i | input | 8 | Byte to write |
| code0_o | output | 8 | Registered setting code, channel 0 |
| code1_o | output | 8 | Registered setting code, channel 1 |

## Verification
The bench walks temperatures across both band edges, including -41, -40, -39, -38, 101, 102, 103 and the most negative input. A design with an off-by-one offset, or one that rounds toward zero for negative offsets, would land in a neighbouring band. A design without clamping would read past either end of the table. The bench writes to the reserved region and to address 00h. A decoder that ignored the upper bound, or that dropped the top address bit, would then corrupt entry 0 or entry 71. The bench also loads a table entry, writes a manual register while in automatic mode, and flips the mode bit, checking the outputs right after each step. A design that drove outputs combinationally from storage, or applied the mode change at once, would change the outputs at the wrong time.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  // Band index for a temperature: offsets below the window clamp to the
  // first band, offsets past the window clamp to the last band.
  function automatic int unsigned tlc_band_of(input int t, input int lo,
                                              input int step, input int n);
    int off;
    if (t < lo) return 0;
    off = (t - lo) / step;
    if (off > n - 1) return n - 1;
    return off;
  endfunction

  // True when a byte address falls inside the table window.
  function automatic logic tlc_in_window(input int addr, input int base,
                                         input int n);
    return (addr >= base) && (addr < base + n);
  endfunction

endpackage

// File: rtl/tlc_index.sv
module tlc_index #(
  parameter int TEMP_W  = 10,
  parameter int T_LOW   = -40,
  parameter int T_STEP  = 2,
  parameter int N_ENTRY = 72,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic signed [TEMP_W-1:0] temp_i,
  output logic        [IDX_W-1:0]  idx_o
);
  import tlc_pkg::*;

  always_comb begin
    idx_o = IDX_W'(tlc_band_of(int'(temp_i), T_LOW, T_STEP, N_ENTRY));
  end

endmodule

// File: rtl/tlc_regs.sv
module tlc_regs #(
  parameter int NUM_CH     = 2,
  parameter int CODE_W     = 8,
  parameter int ADDR_W     = 8,
  parameter int PAGE_W     = 2,
  parameter int N_ENTRY    = 72,
  parameter int CTRL_PAGE  = 1,
  parameter int TBL_PAGE0  = 2,
  parameter int CTRL_ADDR  = 'h80,
  parameter int MAN_ADDR0  = 'h82,
  parameter int TBL_BASE   = 'h80,
  localparam int IDX_W     = $clog2(N_ENTRY)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [PAGE_W-1:0]              wr_page_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [CODE_W-1:0]              wr_data_i,
  output logic                           auto_en_o,
  output logic [NUM_CH-1:0][CODE_W-1:0]  man_q_o,
  output logic [NUM_CH-1:0]              man_we_o,
  output logic [NUM_CH-1:0]              tbl_we_o,
  output logic [IDX_W-1:0]               tbl_entry_o
);
  import tlc_pkg::*;

  logic ctrl_page_hit;
  logic ctrl_we;
  logic in_window;

  assign ctrl_page_hit = wr_en_i && (wr_page_i == PAGE_W'(CTRL_PAGE));
  assign ctrl_we       = ctrl_page_hit && (wr_addr_i == ADDR_W'(CTRL_ADDR));
  assign in_window     = tlc_in_window(int'(wr_addr_i), TBL_BASE, N_ENTRY);
  assign tbl_entry_o   = IDX_W'(wr_addr_i - ADDR_W'(TBL_BASE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      auto_en_o <= 1'b0;
    else if (ctrl_we) auto_en_o <= wr_data_i[0];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign man_we_o[ch] = ctrl_page_hit &&
                          (wr_addr_i == ADDR_W'(MAN_ADDR0 + ch));
    assign tbl_we_o[ch] = wr_en_i && in_window &&
                          (wr_page_i == PAGE_W'(TBL_PAGE0 + ch));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           man_q_o[ch] <= '0;
      else if (man_we_o[ch]) man_q_o[ch] <= wr_data_i;
    end
  end

endmodule

// File: rtl/tlc_table_bank.sv
module tlc_table_bank #(
  parameter int NUM_CH  = 2,
  parameter int CODE_W  = 8,
  parameter int N_ENTRY = 72,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH-1:0]              we_i,
  input  logic [IDX_W-1:0]               wr_entry_i,
  input  logic [CODE_W-1:0]              wr_data_i,
  input  logic [IDX_W-1:0]               rd_idx_i,
  output logic [NUM_CH-1:0][CODE_W-1:0]  rd_data_o
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_tbl
    logic [CODE_W-1:0] mem_q [N_ENTRY];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int e = 0; e < N_ENTRY; e++) mem_q[e] <= '0;
      end else if (we_i[ch]) begin
        mem_q[wr_entry_i] <= wr_data_i;
      end
    end

    assign rd_data_o[ch] = mem_q[rd_idx_i];
  end

endmodule

// File: rtl/tlc_out_stage.sv
module tlc_out_stage #(
  parameter int NUM_CH = 2,
  parameter int CODE_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           conv_i,
  input  logic                           auto_en_i,
  input  logic [NUM_CH-1:0]              man_we_i,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  man_q_i,
  input  logic [CODE_W-1:0]              wr_data_i,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  tbl_rd_i,
  output logic [NUM_CH-1:0][CODE_W-1:0]  code_q_o
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q_o[ch] <= '0;
      end else if (auto_en_i) begin
        if (conv_i) code_q_o[ch] <= tbl_rd_i[ch];
      end else if (man_we_i[ch]) begin
        code_q_o[ch] <= wr_data_i;
      end else if (conv_i) begin
        code_q_o[ch] <= man_q_i[ch];
      end
    end
  end

endmodule

// File: rtl/temp_lut_ctrl.sv
module temp_lut_ctrl #(
  parameter int TEMP_W  = 10,
  parameter int CODE_W  = 8,
  parameter int T_LOW   = -40,
  parameter int T_STEP  = 2,
  parameter int N_ENTRY = 72
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     conv_done_i,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_page_i,
  input  logic [7:0]               wr_addr_i,
  input  logic [CODE_W-1:0]        wr_data_i,
  output logic [CODE_W-1:0]        code0_o,
  output logic [CODE_W-1:0]        code1_o
);
  localparam int NUM_CH = 2;
  localparam int IDX_W  = $clog2(N_ENTRY);

  logic [IDX_W-1:0]              band_idx;
  logic                          auto_en;
  logic [NUM_CH-1:0][CODE_W-1:0] man_q;
  logic [NUM_CH-1:0]             man_we;
  logic [NUM_CH-1:0]             tbl_we;
  logic [IDX_W-1:0]              tbl_entry;
  logic [NUM_CH-1:0][CODE_W-1:0] tbl_rd;
  logic [NUM_CH-1:0][CODE_W-1:0] code_q;

  tlc_index #(
    .TEMP_W(TEMP_W), .T_LOW(T_LOW), .T_STEP(T_STEP), .N_ENTRY(N_ENTRY)
  ) u_index (
    .temp_i(temp_i), .idx_o(band_idx)
  );

  tlc_regs #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(8), .PAGE_W(2),
    .N_ENTRY(N_ENTRY)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_page_i(wr_page_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .auto_en_o(auto_en), .man_q_o(man_q), .man_we_o(man_we),
    .tbl_we_o(tbl_we), .tbl_entry_o(tbl_entry)
  );

  tlc_table_bank #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .N_ENTRY(N_ENTRY)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(tbl_we), .wr_entry_i(tbl_entry),
    .wr_data_i(wr_data_i), .rd_idx_i(band_idx), .rd_data_o(tbl_rd)
  );

  tlc_out_stage #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W)
  ) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .conv_i(conv_done_i),
    .auto_en_i(auto_en), .man_we_i(man_we), .man_q_i(man_q),
    .wr_data_i(wr_data_i), .tbl_rd_i(tbl_rd), .code_q_o(code_q)
  );

  assign code0_o = code_q[0];
  assign code1_o = code_q[1];

endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
  parameter int TEMP_W  = 10,
  parameter int CODE_W  = 8,
  parameter int T_LOW   = -40,
  parameter int T_STEP  = 2,
  parameter int N_ENTRY = 72,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic signed [TEMP_W-1:0] temp,
  input logic                     conv,
  input logic                     auto_en,
  input logic [1:0]               man_we,
  input logic [1:0][CODE_W-1:0]   man_q,
  input logic [CODE_W-1:0]        wr_data,
  input logic [1:0][CODE_W-1:0]   tbl_rd,
  input logic [IDX_W-1:0]         idx,
  input logic [1:0][CODE_W-1:0]   code_q
);
  localparam int T_TOP = T_LOW + T_STEP * (N_ENTRY - 1);

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < N_ENTRY);  // R4
  AST_IDX_HIGH_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(temp) >= T_TOP) |-> (int'(idx) == N_ENTRY - 1));  // R4
  AST_IDX_LOW_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(temp) < T_LOW) |-> (idx == '0));  // R3
  AST_AUTO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && auto_en) |=> (code_q == $past(tbl_rd)));  // R5
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv && man_we == '0) |=> $stable(code_q));  // R6
  AST_MAN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && !auto_en && man_we == '0) |=> (code_q == $past(man_q)));  // R7
  AST_MAN_WRITE0: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && man_we[0]) |=> (code_q[0] == $past(wr_data)));  // R7
  AST_MAN_WRITE1: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && man_we[1]) |=> (code_q[1] == $past(wr_data)));  // R7
  AST_AUTO_IGNORE_MAN: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !conv) |=> $stable(code_q));  // R12

endmodule

bind temp_lut_ctrl tlc_checker #(
  .TEMP_W(TEMP_W), .CODE_W(CODE_W), .T_LOW(T_LOW), .T_STEP(T_STEP),
  .N_ENTRY(N_ENTRY)
) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .temp(temp_i), .conv(conv_done_i),
  .auto_en(auto_en), .man_we(man_we), .man_q(man_q), .wr_data(wr_data_i),
  .tbl_rd(tbl_rd), .idx(band_idx), .code_q(code_q)
);

// File: tb/tb_temp_lut_ctrl.sv
`timescale 1ns/1ps
module tb_temp_lut_ctrl;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [9:0] temp = '0;
  logic              conv = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_page = '0;
  logic [7:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [7:0]        code0, code1;

  int errors = 0;
  int checks = 0;
  logic [7:0] m0 [72];
  logic [7:0] m1 [72];

  always #10 clk = ~clk;

  temp_lut_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .temp_i(temp), .conv_done_i(conv),
    .wr_en_i(wr_en), .wr_page_i(wr_page), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .code0_o(code0), .code1_o(code1)
  );

  // Vector: {temperature, expected band index}
  localparam int NV = 15;
  localparam logic [16:0] VEC [NV] = '{
    {10'(-60), 7'd0},  {10'(-41), 7'd0},  {10'(-40), 7'd0},
    {10'(-39), 7'd0},  {10'(-38), 7'd1},  {10'(0),   7'd20},
    {10'(1),   7'd20}, {10'(25),  7'd32}, {10'(100), 7'd70},
    {10'(101), 7'd70}, {10'(102), 7'd71}, {10'(103), 7'd71},
    {10'(200), 7'd71}, {10'(-3),  7'd18}, {10'(-512), 7'd0}
  };

  function automatic logic [7:0] pat0(input int i);
    return 8'(i * 3 + 5);
  endfunction
  function automatic logic [7:0] pat1(input int i);
    return 8'(255 - i * 2);
  endfunction

  task automatic check(input string req, input logic [7:0] got,
                       input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] pg, input logic [7:0] ad,
                    input logic [7:0] dt);
    @(negedge clk);
    wr_en = 1'b1; wr_page = pg; wr_addr = ad; wr_data = dt;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic strobe(input logic signed [9:0] t);
    @(negedge clk);
    temp = t; conv = 1'b1;
    @(negedge clk);
    conv = 1'b0;
    #1;
  endtask

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset ch0", code0, 8'h00);
    check("R1 reset ch1", code1, 8'h00);

    // R9: load both tables, pages 2 and 3 at 80h + k
    for (int k = 0; k < 72; k++) begin
      m0[k] = pat0(k);
      m1[k] = pat1(k);
      wr(2'd2, 8'(8'h80 + k), m0[k]);
      wr(2'd3, 8'(8'h80 + k), m1[k]);
    end
    check("R6 table load holds ch0", code0, 8'h00);

    // R1: still manual after reset, strobe reloads zero manual regs
    strobe(10'sd50);
    check("R1 manual after reset ch0", code0, 8'h00);
    check("R1 manual after reset ch1", code1, 8'h00);

    // R10: writes outside the table window must not touch any entry
    wr(2'd2, 8'h00, 8'hAA);
    wr(2'd2, 8'hC8, 8'hAA);
    wr(2'd3, 8'hFF, 8'hAA);
    wr(2'd3, 8'h47, 8'hAA);
    wr(2'd0, 8'h80, 8'hAA);
    wr(2'd1, 8'h81, 8'hAA);

    // R8: enable automatic mode; outputs wait for the next strobe
    wr(2'd1, 8'h80, 8'h01);
    check("R8 mode change holds ch0", code0, 8'h00);

    // R2..R5, R11: vector walk in automatic mode
    for (int v = 0; v < NV; v++) begin
      logic signed [9:0] t;
      int e;
      t = VEC[v][16:7];
      e = int'(VEC[v][6:0]);
      strobe(t);
      check($sformatf("R2/R3/R4/R5 ch0 T=%0d", t), code0, m0[e]);
      check($sformatf("R11 ch1 T=%0d", t), code1, m1[e]);
    end

    // R10: boundary entries unchanged after out-of-window writes
    strobe(-10'sd45);
    check("R10 entry0 ch0", code0, pat0(0));
    check("R10 entry0 ch1", code1, pat1(0));
    strobe(10'sd150);
    check("R10 entry71 ch0", code0, pat0(71));
    check("R10 entry71 ch1", code1, pat1(71));

    // R6: rewriting the live entry does not move the output
    wr(2'd2, 8'hC7, 8'h99);
    check("R6 table write holds ch0", code0, pat0(71));
    strobe(10'sd102);
    check("R9 rewritten entry71 ch0", code0, 8'h99);

    // R12: manual write while automatic has no effect on outputs
    wr(2'd1, 8'h82, 8'h11);
    check("R12 manual write in auto ch0", code0, 8'h99);
    check("R12 manual write in auto ch1", code1, pat1(71));

    // R8: back to manual; applies only at strobe
    wr(2'd1, 8'h80, 8'h00);
    check("R8 mode clear holds ch0", code0, 8'h99);
    strobe(10'sd0);
    check("R12 stored manual value ch0", code0, 8'h11);
    check("R7 manual strobe ch1", code1, 8'h00);

    // R7: direct manual writes
    wr(2'd1, 8'h83, 8'h5C);
    check("R7 manual write ch1", code1, 8'h5C);
    check("R7 other channel holds ch0", code0, 8'h11);
    wr(2'd1, 8'h82, 8'h22);
    check("R7 manual write ch0", code0, 8'h22);
    check("R7 other channel holds ch1", code1, 8'h5C);

    // R1: reset in mid-run returns to zero and manual mode
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 second reset ch0", code0, 8'h00);
    strobe(10'sd20);
    check("R1 manual after second reset ch1", code1, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule